// File: doc/BRIEF.md
# Dual 16-bit multiply-accumulate unit

This execute-stage datapath unit multiplies signed 16-bit halfword pairs. It takes two 32-bit operands and an optional 32-bit accumulator. The low halves of the two operands are multiplied together, and so are the high halves. The two signed products are then combined by an add or a subtract. When enabled, the accumulator is added to that combined value. The result is always a wrapped 32-bit value.

The unit also keeps a sticky saturation flag. The flag rises whenever a signed 32-bit overflow occurs in either the product addition or the accumulator addition. Only a dedicated clear input resets it.

Per operation, the control inputs select three things: whether the halves of the second operand are exchanged, whether the products are added or subtracted, and whether the accumulator is included. An operation is taken on a valid strobe. Its result and the updated flag appear one clock later, together with an output strobe.

Top module: `dual_mac16`

## Requirements
- R1: With `swap_i`=0 and `acc_en_i`=0 and `sub_i`=0, the result is (signed `op_a_i[15:0]` × signed `op_b_i[15:0]`) + (signed `op_a_i[31:16]` × signed `op_b_i[31:16]`) modulo 2^32.
- R2: With `swap_i`=1, the two 16-bit halves of `op_b_i` are exchanged before multiplying, so bits [31:16] pair with `op_a_i[15:0]` and bits [15:0] pair with `op_a_i[31:16]`.
- R3: With `sub_i`=1, the combined value is the low-half product minus the high-half product. This step never sets the flag, for example when both operands are 0x80008000.
- R4: With `sub_i`=0, a sum of the two products that lies outside the signed 32-bit range sets `q_o`. For example, both operands 0x80008000 give result 0x80000000 and set `q_o`.
- R5: With `acc_en_i`=1, `acc_i` is added to the wrapped 32-bit combined value. If that addition overflows as a signed 32-bit operation, `q_o` is set.
- R6: The result is never saturated. It always equals the exact value modulo 2^32, including when an overflow occurs. If both additions overflow, `q_o` is simply 1.
- R7: `q_o` is sticky and changes only through new overflow events or `q_clr_i`. A clear with no overflow gives `q_o`=0 after the next edge. An overflow taken in the same cycle as a clear leaves `q_o`=1.
- R8: `valid_o` is 1 exactly in the cycle after a cycle with `valid_i`=1. `result_o` and `q_o` reflect that operation in the same cycle. While `valid_i`=0, `result_o` holds its value.
- R9: During and directly after reset, `valid_o`=0, `result_o`=0 and `q_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe; operands and controls are taken on this cycle |
| swap_i | input | 1 | Exchange the halves of `op_b_i` before multiplying |
| sub_i | input | 1 | 1: subtract high product from low product; 0: add them |
| acc_en_i | input | 1 | Add `acc_i` to the combined product value |
| op_a_i | input | 32 | First operand, two signed halves |
| op_b_i | input | 32 | Second operand, two signed halves |
| acc_i | input | 32 | Accumulator addend |
| q_clr_i | input | 1 | Clear the sticky overflow flag |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| result_o | output | 32 | Wrapped 32-bit result |
| q_o | output | 1 | Sticky signed-overflow flag |

## Verification
Every operation's `result_o`, `valid_o` and flag update are due one rising edge after the cycle in which `valid_i` was high. A flag clear also takes effect one edge after `q_clr_i`.

The bench drives inputs on falling edges. A behavioural model advances on each rising edge, using 64-bit integer arithmetic with explicit range tests. On every following falling edge, all three outputs are compared with the model, so each expectation is sampled exactly one edge after its stimulus. The model tags each expected value with the requirement of the operation that produced it, so a mismatch names that requirement.

// File: rtl/dual_mac16_pkg.sv
package dual_mac16_pkg;
  typedef struct packed {
    logic swap;
    logic sub;
    logic acc_en;
  } dmac_ctrl_t;
endpackage

// File: rtl/dmac_mul.sv
module dmac_mul #(
  parameter int unsigned HALF_W = 16
) (
  input  logic [HALF_W-1:0]   a_i,
  input  logic [HALF_W-1:0]   b_i,
  output logic [2*HALF_W-1:0] p_o
);
  logic signed [2*HALF_W-1:0] a_ext, b_ext;

  always_comb begin
    a_ext = {{HALF_W{a_i[HALF_W-1]}}, a_i};
    b_ext = {{HALF_W{b_i[HALF_W-1]}}, b_i};
    p_o   = a_ext * b_ext;
  end
endmodule

// File: rtl/dmac_combine.sv
module dmac_combine #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] p_lo_i,
  input  logic [DATA_W-1:0] p_hi_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              sub_i,
  input  logic              acc_en_i,
  output logic [DATA_W-1:0] res_o,
  output logic              prod_ovf_o,
  output logic              acc_ovf_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] comb_v, acc_v;

  always_comb begin
    comb_v = sub_i ? (p_lo_i - p_hi_i) : (p_lo_i + p_hi_i);
    // a difference of two 16x16 products always fits; only the sum is checked
    prod_ovf_o = !sub_i && (p_lo_i[MSB] == p_hi_i[MSB]) && (comb_v[MSB] != p_lo_i[MSB]);
    acc_v     = acc_en_i ? acc_i : '0;
    res_o     = comb_v + acc_v;
    acc_ovf_o = acc_en_i && (comb_v[MSB] == acc_i[MSB]) && (res_o[MSB] != comb_v[MSB]);
  end
endmodule

// File: rtl/dual_mac16.sv
module dual_mac16
  import dual_mac16_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                swap_i,
  input  logic                sub_i,
  input  logic                acc_en_i,
  input  logic [2*HALF_W-1:0] op_a_i,
  input  logic [2*HALF_W-1:0] op_b_i,
  input  logic [2*HALF_W-1:0] acc_i,
  input  logic                q_clr_i,
  output logic                valid_o,
  output logic [2*HALF_W-1:0] result_o,
  output logic                q_o
);
  localparam int unsigned DATA_W = 2 * HALF_W;
  localparam int unsigned N_LANE = 2;

  dmac_ctrl_t ctrl;
  assign ctrl = '{swap: swap_i, sub: sub_i, acc_en: acc_en_i};

  logic [HALF_W-1:0] a_h [N_LANE];
  logic [HALF_W-1:0] b_h [N_LANE];
  logic [DATA_W-1:0] prod [N_LANE];

  for (genvar i = 0; i < N_LANE; i++) begin : g_lane
    assign a_h[i] = op_a_i[i*HALF_W +: HALF_W];
    assign b_h[i] = ctrl.swap ? op_b_i[(N_LANE-1-i)*HALF_W +: HALF_W]
                              : op_b_i[i*HALF_W +: HALF_W];
    dmac_mul #(.HALF_W(HALF_W)) u_mul (
      .a_i(a_h[i]),
      .b_i(b_h[i]),
      .p_o(prod[i])
    );
  end

  logic [DATA_W-1:0] res_w;
  logic              prod_ovf_w, acc_ovf_w;

  dmac_combine #(.DATA_W(DATA_W)) u_comb (
    .p_lo_i    (prod[0]),
    .p_hi_i    (prod[1]),
    .acc_i     (acc_i),
    .sub_i     (ctrl.sub),
    .acc_en_i  (ctrl.acc_en),
    .res_o     (res_w),
    .prod_ovf_o(prod_ovf_w),
    .acc_ovf_o (acc_ovf_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      q_o      <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_w;
      // a new event wins over a clear in the same cycle
      q_o <= (q_o && !q_clr_i) || (valid_i && (prod_ovf_w || acc_ovf_w));
    end
  end

  assert_sub_no_ovf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sub_i) |-> !prod_ovf_w);
  assert_min_pair_sets_q_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sub_i && op_a_i == {2{1'b1, {(HALF_W-1){1'b0}}}}
             && op_b_i == {2{1'b1, {(HALF_W-1){1'b0}}}}) |=> q_o);
  assert_q_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !q_clr_i) |=> q_o);
  assert_q_rise_needs_op_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> $past(valid_i));
  assert_valid_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
endmodule

// File: tb/dual_mac16_bench.sv
`timescale 1ns/1ps
module dual_mac16_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, swap = 1'b0, sub = 1'b0, acc_en = 1'b0, clr = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, acc = '0;
  string       req = "R1";
  logic        valid_o, q_o;
  logic [31:0] result_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_mac16 u_dual_mac16 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .swap_i(swap), .sub_i(sub),
    .acc_en_i(acc_en), .op_a_i(op_a), .op_b_i(op_b), .acc_i(acc), .q_clr_i(clr),
    .valid_o(valid_o), .result_o(result_o), .q_o(q_o)
  );

  localparam longint MAXV = 64'sd2147483647;
  localparam longint MINV = -64'sd2147483648;

  function automatic void model(input logic [31:0] a, b, ac, input logic sw, sb, ae,
                                output logic [31:0] r, output bit ov);
    logic [15:0] bl, bh;
    longint pl, ph, c, s;
    bl = sw ? b[31:16] : b[15:0];
    bh = sw ? b[15:0]  : b[31:16];
    pl = longint'($signed(a[15:0]))  * longint'($signed(bl));
    ph = longint'($signed(a[31:16])) * longint'($signed(bh));
    c  = sb ? pl - ph : pl + ph;
    ov = (c > MAXV) || (c < MINV);
    s  = longint'($signed(c[31:0]));
    if (ae) begin
      s = s + longint'($signed(ac));
      if ((s > MAXV) || (s < MINV)) ov = 1'b1;
    end
    r = s[31:0];
  endfunction

  // reference state, advanced on each rising edge
  logic        e_valid = 1'b0, e_q = 1'b0;
  logic [31:0] e_res = '0;
  string       e_req = "R9";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid = 1'b0; e_res = '0; e_q = 1'b0; e_req = "R9";
    end else begin
      logic [31:0] r;
      bit ov;
      model(op_a, op_b, acc, swap, sub, acc_en, r, ov);
      e_valid = valid;
      if (valid) begin
        e_res = r;
        e_req = req;
      end else begin
        e_req = clr ? "R7" : "R8";
      end
      e_q = (e_q && !clr) || (valid && ov);
    end
  end

  task automatic check(input string r, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(e_req, "valid_o", {31'd0, valid_o}, {31'd0, e_valid});
      check(e_req, "result_o", result_o, e_res);
      check(e_req, "q_o", {31'd0, q_o}, {31'd0, e_q});
    end
  end

  task automatic op(input string r, input logic [31:0] a, b, ac,
                    input logic sw, sb, ae, cl);
    @(negedge clk);
    req = r; valid = 1'b1; op_a = a; op_b = b; acc = ac;
    swap = sw; sub = sb; acc_en = ae; clr = cl;
  endtask

  task automatic idle(input logic cl);
    @(negedge clk);
    valid = 1'b0; clr = cl;
    op_a = 32'hdead_beef; op_b = 32'h1234_5678; acc = 32'h7fff_ffff;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "valid_o", {31'd0, valid_o}, 32'd0);
    check("R9", "result_o", result_o, 32'd0);
    check("R9", "q_o", {31'd0, q_o}, 32'd0);
    rst_n = 1'b1;
    idle(1'b0);
    op("R1", 32'h0003_0002, 32'h0005_0004, '0, 0, 0, 0, 0);   // 8 + 15
    op("R1", 32'hfffd_0007, 32'h0005_fffc, '0, 0, 0, 0, 0);   // negatives
    op("R2", 32'h0003_0002, 32'h0005_0004, '0, 1, 0, 0, 0);   // 10 + 12
    op("R2", 32'h8000_0001, 32'h7fff_8000, '0, 1, 0, 0, 0);
    op("R3", 32'h8000_8000, 32'h8000_8000, '0, 0, 1, 0, 0);   // 0, no flag
    op("R3", 32'h8000_7fff, 32'h7fff_7fff, '0, 0, 1, 0, 0);   // large difference
    idle(1'b0);
    op("R4", 32'h8000_8000, 32'h8000_8000, '0, 0, 0, 0, 0);   // 0x80000000, flag
    idle(1'b0);
    idle(1'b0);                                               // R7 flag holds
    idle(1'b1);                                               // R7 clear
    idle(1'b0);
    op("R5", 32'h0000_0001, 32'h0000_0001, 32'h7fff_ffff, 0, 0, 1, 0);
    op("R7", 32'h0000_0001, 32'h0000_0001, 32'h0000_0005, 0, 0, 1, 1); // clear, no event
    op("R7", 32'h8000_8000, 32'h8000_8000, 32'h0000_0000, 0, 0, 0, 1); // clear with event
    idle(1'b1);
    op("R6", 32'h8000_8000, 32'h8000_8000, 32'h8000_0000, 0, 0, 1, 0); // both overflow, 0
    idle(1'b1);
    op("R5", 32'h0002_0003, 32'h0004_0005, 32'hffff_ff00, 0, 1, 1, 0);  // no overflow
    op("R6", 32'h7fff_7fff, 32'h7fff_7fff, 32'h7fff_ffff, 0, 0, 1, 0);  // wraps
    idle(1'b1);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a, b, c;
      a = $urandom; b = $urandom; c = $urandom;
      if (k % 5 == 0) a = 32'h8000_8000;
      if (k % 7 == 0) b = 32'h8000_8000;
      if (k % 3 == 0) begin
        op("R5", a, b, c, k[1], k[2], 1'b1, k % 11 == 0);
      end else begin
        op("R1", a, b, c, k[1], k[2], 1'b0, k % 11 == 0);
      end
      if (k % 4 == 0) idle(k % 8 == 0);
    end
    idle(1'b0);
    idle(1'b0);
    @(negedge clk);
    finish_run();
  end
endmodule